// File: doc/BRIEF.md
# Atomic-Update GPIO Port

This block is a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. The bus has single-cycle read and write strobes, a word address and a 32-bit data path. The port keeps two state registers: an output latch and a direction word. It also gives software three write-only aliases. Through these aliases one bus write can raise, lower or flip any chosen group of output bits, with no read-modify-write sequence.

On the pin side, every pin carries four signals: a driven value, an output enable, a sampled input level and a digital-use enable. One port-wide enable sits beside them. Input levels pass through a synchroniser and are then captured into a read-only input word. Pins that are not in digital use read as zero. The captured word freezes while the port enable is low. A parameter mask marks the pins that exist. A pin outside the mask never drives and always reads zero.

Word indices on the bus: 0 is the output latch, 1 is the raise alias, 2 is the lower alias, 3 is the flip alias, 4 is the input word and 5 is the direction word. Every other index is unmapped.

Top module: `gpio_atomic_port`

## Requirements
- R1: While reset is held and on the first cycle after it, `pin_out` and `pin_oe` are all zero, and word 0 and word 5 read 0x00000000.
- R2: A write to word 0 loads the output latch with `bus_wdata`. From the next clock edge, `pin_out` equals that value and word 0 reads it back.
- R3: A write to word 1 sets to 1 every latch bit whose `bus_wdata` bit is 1. All other latch bits keep their value.
- R4: A write to word 2 clears to 0 every latch bit whose `bus_wdata` bit is 1. All other latch bits keep their value.
- R5: A write to word 3 inverts every latch bit whose `bus_wdata` bit is 1. All other latch bits keep their value.
- R6: Reads of words 1, 2 and 3 always return zero.
- R7: A write to word 5 loads the direction word, which reads back at word 5. Bit value 1 means output and 0 means input. From the next edge, `pin_oe` equals the direction word ANDed with `IMPL_MASK`. With no bus write, `pin_out` and `pin_oe` hold their values.
- R8: Word 4 shows the pin inputs after a two-flop synchroniser and a capture register. A change on `pin_in` that is driven before clock edge 1 is readable after edge 3, and is not yet readable after edge 2.
- R9: Any bit of word 4 whose `pin_dig_en` bit was 0 at the capture edge reads 0.
- R10: While `port_en` is 0, word 4 keeps its last captured value. When `port_en` returns to 1, capturing resumes.
- R11: Bits outside `IMPL_MASK` (default 0x0FFFFFFF) always read 0 in word 4, and their `pin_oe` is always 0.
- R12: Writes to word 4 and to unmapped indices (6 to 15) change no state. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at this clock edge |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_addr | input | ADDR_W (4) | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed word while `bus_rd` is high; zero otherwise |
| pin_out | output | 32 | Per-pin driven value |
| pin_oe | output | 32 | Per-pin output enable |
| pin_in | input | 32 | Per-pin input level, asynchronous |
| pin_dig_en | input | 32 | Per-pin digital-use enable |
| port_en | input | 1 | Port-wide enable for input capture |

## Verification
Register writes take effect at the edge on which `bus_wr` is high. The bench therefore checks `pin_out`, `pin_oe` and the readback at the following falling edge. Reads are combinational, so the bench samples `bus_rdata` one nanosecond after it raises `bus_rd` at a falling edge, well before the next rising edge. An input change needs three rising edges to reach word 4. The bench checks this window exactly: it expects the old value after the second edge and the new value after the third. All other input checks wait four edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DATA_W = 32;

  // Bus word indices (byte offset / 4)
  localparam int IDX_OUT = 0;
  localparam int IDX_SET = 1;
  localparam int IDX_CLR = 2;
  localparam int IDX_TGL = 3;
  localparam int IDX_IN  = 4;
  localparam int IDX_DIR = 5;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_SET, OP_CLR, OP_TGL, OP_DIR
  } wr_op_e;

  typedef enum logic [1:0] {
    RS_ZERO, RS_OUT, RS_IN, RS_DIR
  } rd_sel_e;

  // Next value of the output latch for a given write operation
  function automatic word_t next_out(wr_op_e op, word_t cur, word_t wd);
    case (op)
      OP_LOAD: return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TGL:  return cur ^ wd;
      default: return cur;
    endcase
  endfunction

  // Input word after digital-use and implemented-pin gating
  function automatic word_t gate_in(word_t raw, word_t dig, word_t impl);
    return raw & dig & impl;
  endfunction
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_op_e            wr_op,
  output rd_sel_e           rd_sel
);
  always_comb begin
    wr_op = OP_NONE;
    if (bus_wr) begin
      if      (bus_addr == ADDR_W'(IDX_OUT)) wr_op = OP_LOAD;
      else if (bus_addr == ADDR_W'(IDX_SET)) wr_op = OP_SET;
      else if (bus_addr == ADDR_W'(IDX_CLR)) wr_op = OP_CLR;
      else if (bus_addr == ADDR_W'(IDX_TGL)) wr_op = OP_TGL;
      else if (bus_addr == ADDR_W'(IDX_DIR)) wr_op = OP_DIR;
      else                                   wr_op = OP_NONE;
    end
  end

  always_comb begin
    if      (bus_addr == ADDR_W'(IDX_OUT)) rd_sel = RS_OUT;
    else if (bus_addr == ADDR_W'(IDX_IN))  rd_sel = RS_IN;
    else if (bus_addr == ADDR_W'(IDX_DIR)) rd_sel = RS_DIR;
    else                                   rd_sel = RS_ZERO;
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  wr_op_e wr_op,
  input  word_t  wdata,
  output word_t  out_q,
  output word_t  dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= next_out(wr_op, out_q, wdata);
      if (wr_op == OP_DIR) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_in_sampler.sv
module gpio_in_sampler
  import gpio_port_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter word_t IMPL_MASK   = 32'h0FFF_FFFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t pin_in,
  input  word_t pin_dig_en,
  input  logic  port_en,
  output word_t in_q
);
  localparam int LAST = SYNC_STAGES - 1;

  word_t sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_q <= '0;
    else if (port_en) in_q <= gate_in(sync_q[LAST], pin_dig_en, IMPL_MASK);
  end
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_port_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] IMPL_MASK   = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  input  logic [31:0]       pin_in,
  input  logic [31:0]       pin_dig_en,
  input  logic              port_en
);
  wr_op_e  wr_op;
  rd_sel_e rd_sel;
  word_t   out_data;
  word_t   dir_data;
  word_t   in_data;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_op    (wr_op),
    .rd_sel   (rd_sel)
  );

  gpio_out_regs u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_op (wr_op),
    .wdata (bus_wdata),
    .out_q (out_data),
    .dir_q (dir_data)
  );

  gpio_in_sampler #(.SYNC_STAGES(SYNC_STAGES), .IMPL_MASK(IMPL_MASK)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .pin_dig_en (pin_dig_en),
    .port_en    (port_en),
    .in_q       (in_data)
  );

  assign pin_out = out_data;

  // Output enable per pin: tied low on pins outside the implemented mask
  for (genvar p = 0; p < DATA_W; p++) begin : g_oe
    if (IMPL_MASK[p]) begin : g_live
      assign pin_oe[p] = dir_data[p];
    end else begin : g_absent
      assign pin_oe[p] = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (rd_sel)
        RS_OUT:  bus_rdata = out_data;
        RS_IN:   bus_rdata = in_data;
        RS_DIR:  bus_rdata = dir_data;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk
  import gpio_port_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0FFF_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe,
  input logic [31:0]       pin_dig_en,
  input logic              port_en,
  input logic [31:0]       in_data
);
  logic wr_load, wr_set, wr_clr, wr_tgl, wr_dir, wr_dead, rd_alias, rd_unmapped;
  assign wr_load = bus_wr && bus_addr == ADDR_W'(IDX_OUT);
  assign wr_set  = bus_wr && bus_addr == ADDR_W'(IDX_SET);
  assign wr_clr  = bus_wr && bus_addr == ADDR_W'(IDX_CLR);
  assign wr_tgl  = bus_wr && bus_addr == ADDR_W'(IDX_TGL);
  assign wr_dir  = bus_wr && bus_addr == ADDR_W'(IDX_DIR);
  assign wr_dead = bus_wr && !(wr_load || wr_set || wr_clr || wr_tgl || wr_dir);
  assign rd_alias = bus_rd && (bus_addr == ADDR_W'(IDX_SET) || bus_addr == ADDR_W'(IDX_CLR)
                               || bus_addr == ADDR_W'(IDX_TGL));
  assign rd_unmapped = bus_rd && bus_addr > ADDR_W'(IDX_DIR);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> pin_out == $past(bus_wdata));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
               ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0) &&
               ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgl |=> (pin_out ^ $past(pin_out)) == $past(bus_wdata));

  assert_alias_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_alias |-> bus_rdata == '0);

  assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == ($past(bus_wdata) & IMPL_MASK));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out) && $stable(pin_oe));

  assert_dig_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> (in_data & ~$past(pin_dig_en)) == '0);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_data));

  assert_absent_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_data & ~IMPL_MASK) == '0) && ((pin_oe & ~IMPL_MASK) == '0));

  assert_dead_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dead |=> $stable(pin_out) && $stable(pin_oe));

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> bus_rdata == '0);
endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_dig_en (pin_dig_en),
  .port_en    (port_en),
  .in_data    (in_data)
);

// File: tb/gpio_atomic_port_bench.sv
module gpio_atomic_port_bench;
  localparam logic [31:0] MASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_dig_en = '0;
  logic        port_en = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;
  logic [31:0] got;
  logic [31:0] held;

  always #2 clk = ~clk;

  gpio_atomic_port u_gpio_atomic_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in),
    .pin_dig_en(pin_dig_en), .port_en(port_en)
  );

  function automatic logic [31:0] model_write(int idx, logic [31:0] cur, logic [31:0] w);
    if (idx == 0) return w;
    if (idx == 1) return cur | w;
    if (idx == 2) return cur & ~w;
    if (idx == 3) return cur ^ w;
    return cur;
  endfunction

  function automatic logic [31:0] model_input(logic [31:0] p, logic [31:0] d);
    return p & d & MASK;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a <= 4'd3) m_out = model_write(int'(a), m_out, d);
    if (a == 4'd5) m_dir = d;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    logic [31:0] r;
    bus_read(4'd0, r);
    check({tag, " word0"}, r, m_out);
    check({tag, " pin_out"}, pin_out, m_out);
    bus_read(4'd5, r);
    check({tag, " word5"}, r, m_dir);
    check({tag, " pin_oe"}, pin_oe, m_dir & MASK);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    rst_n = 1'b1;
    check_outputs("R1 after reset");

    // Directed aliases
    bus_write(4'd0, 32'hF0F0_1234); check_outputs("R2 load");
    bus_write(4'd1, 32'h0F00_0001); check_outputs("R3 set");
    bus_write(4'd2, 32'hF000_0030); check_outputs("R4 clear");
    bus_write(4'd3, 32'hFFFF_0000); check_outputs("R5 toggle");
    bus_write(4'd5, 32'hFFFF_FFFF); check_outputs("R7 dir all ones (R11 masks oe)");
    check("R11 oe top nibble", pin_oe & ~MASK, 32'h0);
    for (int a = 1; a <= 3; a++) begin
      bus_read(4'(a), got);
      check("R6 alias reads zero", got, 32'h0);
    end

    // Random mix of writes across all indices
    for (int i = 0; i < 300; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 15));
      d = $urandom;
      bus_write(a, d);
      if (a == 4'd4 || a > 4'd5) check_outputs("R12 ignored write");
      else if (a == 4'd1) check_outputs("R3 random set");
      else if (a == 4'd2) check_outputs("R4 random clear");
      else if (a == 4'd3) check_outputs("R5 random toggle");
      else if (a == 4'd5) check_outputs("R7 random dir");
      else check_outputs("R2 random load");
      if (a > 4'd5) begin
        bus_read(a, got);
        check("R12 unmapped read", got, 32'h0);
      end
      if (a >= 4'd1 && a <= 4'd3) begin
        bus_read(a, got);
        check("R6 alias read", got, 32'h0);
      end
    end

    // Input path
    port_en = 1'b1;
    pin_dig_en = 32'hFFFF_FFFF;
    @(negedge clk); pin_in = 32'hA5A5_1234;
    repeat (4) @(negedge clk);
    bus_read(4'd4, got);
    check("R8 R11 input capture", got, model_input(32'hA5A5_1234, 32'hFFFF_FFFF));
    // Exact latency: changed at a falling edge; old after 2 edges, new after 3
    pin_in = 32'h0123_4567;
    @(negedge clk); @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'd4; #1 got = bus_rdata; bus_rd = 1'b0;
    check("R8 not yet after two edges", got, model_input(32'hA5A5_1234, 32'hFFFF_FFFF));
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'd4; #1 got = bus_rdata; bus_rd = 1'b0;
    check("R8 visible after three edges", got, model_input(32'h0123_4567, 32'hFFFF_FFFF));

    pin_in = 32'hFFFF_FFFF; pin_dig_en = 32'h0000_FFFF;
    repeat (4) @(negedge clk);
    bus_read(4'd4, got);
    check("R9 digital gating", got, 32'h0000_FFFF);
    pin_dig_en = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    bus_read(4'd4, held);
    check("R11 input mask", held, MASK);

    port_en = 1'b0; pin_in = 32'h0;
    repeat (6) @(negedge clk);
    bus_read(4'd4, got);
    check("R10 frozen while disabled", got, held);
    bus_write(4'd4, 32'h1234_5678);
    bus_read(4'd4, got);
    check("R12 write to input word ignored", got, held);
    check_outputs("R12 input word write leaves outputs");
    port_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(4'd4, got);
    check("R10 resumes on enable", got, 32'h0);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] p;
      logic [31:0] dg;
      p = $urandom; dg = $urandom;
      pin_in = p; pin_dig_en = dg;
      repeat (4) @(negedge clk);
      bus_read(4'd4, got);
      check("R9 R11 random input", got, model_input(p, dg));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule